// File: doc/BRIEF.md
# Host Command Register with Completion Handshake

This block sits between a 32-bit host bus and an internal serial-link controller. The host writes a 16-bit command into the low half of a bus word. The block checks whether the command may be taken at that moment. It then splits the command into its fields and sends a one-cycle launch pulse to the controller. The command stays in the register while the controller works. The controller reports completion on a single done input, and the block then clears the register to zero. Host software polls the register and treats a zero read as "finished".

Some writes are refused or ignored by fixed rules. A word with its top bit set is dropped without any trace, so hosts that replay a fixed write list can skip the register. A normal command that arrives while another one is pending is refused, and a sticky error flag records that. The stop-all command is the exception: it is always taken. When it replaces a pending command, it aborts that command.

Top module: `host_cmd_reg`

## Requirements
- R1: A synchronous active-high reset clears the command register and the error flag. After reset, `host_rdata` reads 0 and `cmd_valid` and `cmd_abort` are low.
- R2: The command fields come out of the stored command as follows: bit 15 on `cmd_write`, bit 14 on `cmd_rom`, bit 13 on `cmd_request`, bit 12 on `cmd_doit`, bit 11 on `cmd_startstop`, bits 10:8 on `cmd_type`, and bits 7:0 on `cmd_chan`. Each bit of `cmd_chan` selects the channel with the same index.
- R3: Operation decode uses bits 15:8 of the stored command. 0x08 drives `op_stop` (stop the interface). 0x09 drives `op_start_norm` (start in normal mode). 0x0F drives `op_start_setup` (start in setup mode). Any other value drives none of the three.
- R4: An accepted command is held in the register from the clock edge that samples the write. `cmd_valid` is high for exactly the following cycle, with the fields of that command.
- R5: `host_rdata` is {15 zero bits, error flag, stored command}. A pending command therefore reads back as the last accepted command.
- R6: While a command is pending, `ctl_done` clears the register to zero at the next clock edge. When the register is already zero, `ctl_done` has no effect.
- R7: A write with bit 31 set changes neither the register nor the error flag, and it produces no pulse.
- R8: A write whose low half is not 0x08FF is refused while the register is non-zero. The register keeps its value, no pulse follows, and the error flag (read bit 16) is set.
- R9: Once set, the error flag stays set until reset, through completions and later accepted commands.
- R10: The stop-all command 0x08FF is accepted whether or not the register is zero. If a command was pending, `cmd_abort` is high in the same cycle as the `cmd_valid` for the stop-all.
- R11: A write of command 0x0000 while the register is zero is not launched. No pulse follows and the register stays zero.
- R12: Bits 30:16 of a write word play no part in the decision or in the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe, one word per cycle |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Readback: error flag at bit 16, command at bits 15:0 |
| ctl_done | input | 1 | Controller reports that the pending command has finished |
| cmd_valid | output | 1 | One-cycle launch pulse for an accepted command |
| cmd_abort | output | 1 | The pending command is aborted by stop-all (coincides with cmd_valid) |
| cmd_write | output | 1 | Control-data write flag |
| cmd_rom | output | 1 | Processor reset / ROM load flag |
| cmd_request | output | 1 | Read or write request flag |
| cmd_doit | output | 1 | Do-it flag |
| cmd_startstop | output | 1 | Start/stop flag |
| cmd_type | output | 3 | Start/stop type |
| cmd_chan | output | 8 | Channel select mask |
| op_stop | output | 1 | Decoded stop |
| op_start_norm | output | 1 | Decoded start in normal mode |
| op_start_setup | output | 1 | Decoded start in setup mode |

## Verification
The assertions assume that `ctl_done` comes only while a command is pending. They also assume that it never comes in the same cycle as a host write, because the outcome of that collision is a priority choice and not a checked behaviour. The stimulus issues each write and each completion in its own cycle, with an idle cycle between them. Completions are sent only after a command has been observed as pending, except for one deliberate done pulse on an idle register.

// File: rtl/host_cmd_reg.sv
module host_cmd_reg #(
  parameter int HOST_W = 32,
  parameter int CMD_W  = 16,
  parameter logic [15:0] STOP_ALL = 16'h08FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              ctl_done,
  output logic              cmd_valid,
  output logic              cmd_abort,
  output logic              cmd_write,
  output logic              cmd_rom,
  output logic              cmd_request,
  output logic              cmd_doit,
  output logic              cmd_startstop,
  output logic [2:0]        cmd_type,
  output logic [7:0]        cmd_chan,
  output logic              op_stop,
  output logic              op_start_norm,
  output logic              op_start_setup
);
  localparam int ERR_BIT = CMD_W;
  localparam int PAD_W   = HOST_W - CMD_W - 1;

  logic [CMD_W-1:0] cmd_q;
  logic             err_q;

  logic             skip_w;
  logic [CMD_W-1:0] new_cmd;
  logic             busy;
  logic             is_stop_all;
  logic             take;
  logic             refuse;

  assign skip_w      = host_wdata[HOST_W-1];
  assign new_cmd     = host_wdata[CMD_W-1:0];
  assign busy        = |cmd_q;
  assign is_stop_all = (new_cmd == STOP_ALL);
  assign take        = host_wr && !skip_w && (is_stop_all || (!busy && |new_cmd));
  assign refuse      = host_wr && !skip_w && busy && !is_stop_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      err_q     <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_abort <= 1'b0;
    end else begin
      cmd_valid <= take;
      cmd_abort <= take && is_stop_all && busy;
      if (refuse)
        err_q <= 1'b1;
      if (take)
        cmd_q <= new_cmd;
      else if (ctl_done)
        cmd_q <= '0;
    end
  end

  assign host_rdata    = {{PAD_W{1'b0}}, err_q, cmd_q};

  assign cmd_write     = cmd_q[15];
  assign cmd_rom       = cmd_q[14];
  assign cmd_request   = cmd_q[13];
  assign cmd_doit      = cmd_q[12];
  assign cmd_startstop = cmd_q[11];
  assign cmd_type      = cmd_q[10:8];
  assign cmd_chan      = cmd_q[7:0];

  assign op_stop        = (cmd_q[15:8] == 8'h08);
  assign op_start_norm  = (cmd_q[15:8] == 8'h09);
  assign op_start_setup = (cmd_q[15:8] == 8'h0F);

  a_r4_valid_has_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);

  a_r7_skip_no_effect: assert property (@(posedge clk) disable iff (rst)
    (host_wr && skip_w && !ctl_done) |=> ($stable(cmd_q) && $stable(err_q) && !cmd_valid));

  a_r6_done_clears: assert property (@(posedge clk) disable iff (rst)
    (ctl_done && !host_wr) |=> (cmd_q == '0));

  a_r8_refuse_flags: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !skip_w && busy && !is_stop_all) |=> (err_q && !cmd_valid));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  a_r10_abort_with_stop: assert property (@(posedge clk) disable iff (rst)
    cmd_abort |-> (cmd_valid && cmd_q == STOP_ALL));

  a_r11_zero_idle: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !skip_w && !busy && new_cmd == '0) |=> !cmd_valid);

  a_r3_one_op: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_stop, op_start_norm, op_start_setup}));
endmodule

// File: tb/test_host_cmd_reg.sv
module test_host_cmd_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        ctl_done = 1'b0;
  logic        cmd_valid, cmd_abort, cmd_write, cmd_rom, cmd_request, cmd_doit, cmd_startstop;
  logic [2:0]  cmd_type;
  logic [7:0]  cmd_chan;
  logic        op_stop, op_start_norm, op_start_setup;

  int checks = 0;
  int fails  = 0;
  logic [16:0] exp_q[$];
  logic [15:0] m_cmd = '0;
  logic        m_err = 1'b0;

  always #4 clk = ~clk;

  host_cmd_reg i_host_cmd_reg (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ctl_done(ctl_done), .cmd_valid(cmd_valid),
    .cmd_abort(cmd_abort), .cmd_write(cmd_write), .cmd_rom(cmd_rom),
    .cmd_request(cmd_request), .cmd_doit(cmd_doit), .cmd_startstop(cmd_startstop),
    .cmd_type(cmd_type), .cmd_chan(cmd_chan), .op_stop(op_stop),
    .op_start_norm(op_start_norm), .op_start_setup(op_start_setup)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] d);
    logic [15:0] c;
    c = d[15:0];
    @(negedge clk);
    if (!d[31]) begin
      if (c == 16'h08FF) begin
        exp_q.push_back({m_cmd != 0, c});
        m_cmd = c;
      end else if (m_cmd != 0) begin
        m_err = 1'b1;
      end else if (c != 0) begin
        exp_q.push_back({1'b0, c});
        m_cmd = c;
      end
    end
    host_wr = 1'b1;
    host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    host_wdata = '0;
  endtask

  task automatic finish_cmd();
    @(negedge clk);
    ctl_done = 1'b1;
    m_cmd = '0;
    @(negedge clk);
    ctl_done = 1'b0;
  endtask

  task automatic check_read(input string req);
    check(req, host_rdata, {15'b0, m_err, m_cmd});
  endtask

  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      logic [16:0] e;
      logic [2:0]  ops;
      if (exp_q.size() == 0) begin
        check("R4 unexpected pulse", 32'(host_rdata[15:0]), 32'h0);
      end else begin
        e = exp_q.pop_front();
        check("R4 launched command", 32'(host_rdata[15:0]), 32'(e[15:0]));
        check("R10 abort", 32'(cmd_abort), 32'(e[16]));
        check("R2 fields",
              32'({cmd_write, cmd_rom, cmd_request, cmd_doit, cmd_startstop, cmd_type, cmd_chan}),
              32'(e[15:0]));
        ops = {e[15:8] == 8'h08, e[15:8] == 8'h09, e[15:8] == 8'h0F};
        check("R3 op decode", 32'({op_stop, op_start_norm, op_start_setup}), 32'(ops));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset readback", host_rdata, 32'h0);
    check("R1 reset pulses", 32'({cmd_valid, cmd_abort}), 32'h0);

    host_write(32'h0000_0901);
    check_read("R5 pending readback");
    @(negedge clk);
    check("R4 single-cycle pulse", 32'(cmd_valid), 32'h0);
    check_read("R5 still pending");
    finish_cmd();
    check_read("R6 done clears");

    finish_cmd();
    check_read("R6 done on idle ignored");

    host_write(32'h8000_0A33);
    @(negedge clk);
    check_read("R7 ignored while idle");

    host_write(32'h0000_0F80);
    host_write(32'h8000_0905);
    @(negedge clk);
    check_read("R7 ignored while pending");
    host_write(32'h0000_2001);
    @(negedge clk);
    check("R8 refused sets error", host_rdata, 32'h0001_0F80);
    finish_cmd();
    check("R9 error survives done", host_rdata, 32'h0001_0000);

    host_write(32'h0000_0904);
    host_write(32'h0000_08FF);
    @(negedge clk);
    check("R10 stop-all replaces", host_rdata, 32'h0001_08FF);
    finish_cmd();
    host_write(32'h0000_08FF);
    @(negedge clk);
    check_read("R10 stop-all idle");
    finish_cmd();

    host_write(32'h0000_0000);
    @(negedge clk);
    check_read("R11 zero command idle");

    host_write(32'h7FFF_9055);
    @(negedge clk);
    check("R12 high bits ignored", host_rdata, 32'h0001_9055);
    check("R2 write flag", 32'(cmd_write), 32'h1);
    finish_cmd();

    host_write(32'h0000_0812);
    finish_cmd();
    check("R9 error after new command", 32'(host_rdata[16]), 32'h1);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_err = 1'b0;
    m_cmd = '0;
    check("R1 reset clears error", host_rdata, 32'h0);

    repeat (3) @(negedge clk);
    check("R4 all pulses seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule